// File: doc/BRIEF.md
# Ping-Pong Dual-Channel DMA Requester

This block sits on the peripheral side of a host DMA controller. It streams samples from a data source into memory using two host DMA channels, a primary and a secondary. Each sample strobe loads a small holding FIFO. While the active channel is armed, the block raises that channel's request line and presents the oldest held sample. A transfer completes when the host acknowledges the request.

The host marks the last transfer of a channel's programmed block by asserting terminal count together with the acknowledge. On that transfer the block does three things in the same edge:
- It disarms the finished channel.
- It latches an interrupt flag that names the finished channel.
- It moves all further requests to the other channel.

This leaves software a whole block's worth of time to reprogram and re-arm the finished channel, with no gap in the sample stream.

Software arms a channel by pulsing its ready input. It clears a channel's interrupt by pulsing that channel's clear input. If the block must switch to a channel that has not been re-armed, it records an underrun and stops requesting. If a sample arrives while the FIFO is full, it records an overrun.

Top module: `pingpong_dma_req`

## Requirements
- R1: After reset, both request lines are low, both interrupt flags are low, the primary channel (active_ch = 0) is active, and the overrun and underrun flags are low.
- R2: At most one request line is high at a time. dma_req[c] is high exactly when all four of these hold: channel c is active, channel c is armed, the FIFO holds at least one sample, and no underrun has been recorded.
- R3: A raised request stays high, and xfer_data stays stable, until that channel's acknowledge is sampled high. A handshake is a cycle with dma_req[c] and dma_ack[c] both high. Each handshake removes the oldest sample, and samples leave in arrival order.
- R4: An acknowledge on a channel whose request is low transfers nothing and changes no state.
- R5: A handshake with dma_tc[c] high on the active channel c does three things at the next clock edge: it sets irq[c], it disarms channel c, and it makes the other channel active.
- R6: A terminal-count pulse outside a handshake has no effect: the active channel and the interrupt flags are unchanged.
- R7: irq_clr[c] = 1 clears irq[c] at the next edge. If a completion on channel c occurs in the same cycle, the set wins.
- R8: The FIFO holds four samples. A strobe arriving while four samples are held is dropped, even if one leaves in that cycle, and it sets the overrun flag. The overrun flag stays set until reset.
- R9: If the channel being switched to is not armed after that cycle, the underrun flag is set. It counts as armed if it was already armed or if its ready input is pulsed in the same cycle. Once underrun is set, no request is raised until reset.
- R10: A sample held across a switch is requested on the new channel in the cycle right after the switch, with no sample lost.
- R11: A ready pulse arms a channel. If that channel completes in the same cycle, the completion's disarm wins over the ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe: a new sample is present |
| sample_data | input | DATA_W | Sample value |
| dma_req | output | 2 | Request line per channel (bit 0 primary, bit 1 secondary) |
| dma_ack | input | 2 | Host acknowledge per channel |
| dma_tc | input | 2 | Host terminal-count indication per channel |
| xfer_data | output | DATA_W | Oldest held sample, driven while requesting |
| ready_set | input | 2 | Software pulse that arms a channel |
| irq_clr | input | 2 | Software write-one-to-clear of a channel's interrupt |
| irq | output | 2 | Completion interrupt per channel |
| active_ch | output | 1 | Channel currently served (0 primary, 1 secondary) |
| overrun | output | 1 | Sticky: a sample was dropped because the FIFO was full |
| underrun | output | 1 | Sticky: a switch hit a channel that was not armed |

## Verification
The assertions check the following on every cycle:
- the one-hot request lines;
- request and data holding until acknowledge;
- the channel swap and interrupt set on a completing handshake;
- the stickiness of the error flags;
- the silence of the request lines after an underrun.

Data ordering, dropping of samples on a full FIFO, the set-over-clear collision, the behaviour of ignored acknowledges and terminal counts, and continuity across a switch can only be shown by the bench. The bench does this by comparing each cycle's outputs against a model of the requirements, driven by random host and software activity and by directed sequences.

// File: rtl/pingpong_pkg.sv
// Shared types for the ping-pong DMA requester.
// Assumes exactly two host channels; index 0 is the primary.
package pingpong_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_PRI = 1'b0,
        CH_SEC = 1'b1
    } chan_e;
endpackage

// File: rtl/pp_sample_fifo.sv
// Sample holding FIFO.
// Accepts a push only when not full; the caller gets a drop pulse instead.
// A pop is expected only when the FIFO is non-empty.
// Assumes DEPTH is a power of two.
module pp_sample_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              full, do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rd_ptr];

    // Storage write; holds no reset, content is qualified by count.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pp_chan_seq.sv
// Channel sequencer.
// Tracks the active channel, the per-channel armed bits and interrupt flags,
// and the sticky underrun flag.
// Assumes 'finish' is asserted only for a handshake on the active channel
// with terminal count.
module pp_chan_seq
    import pingpong_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic [NUM_CH-1:0] ready_set,
    input  logic [NUM_CH-1:0] irq_clr,
    output logic [NUM_CH-1:0] armed,
    output logic [NUM_CH-1:0] irq,
    output chan_e             active,
    output logic              underrun
);
    logic [NUM_CH-1:0] done_vec;
    logic [NUM_CH-1:0] armed_nx;
    chan_e             other;

    assign other = (active == CH_PRI) ? CH_SEC : CH_PRI;

    // Decode which channel finishes this cycle.
    always_comb begin
        done_vec = '0;
        if (finish) begin
            done_vec[active] = 1'b1;
        end
    end

    // Next armed state: a completion disarm wins over a same-cycle ready pulse.
    assign armed_nx = (armed | ready_set) & ~done_vec;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Per-channel armed bit and interrupt flag; set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed[i] <= 1'b0;
                irq[i]   <= 1'b0;
            end else begin
                armed[i] <= armed_nx[i];
                irq[i]   <= done_vec[i] | (irq[i] & ~irq_clr[i]);
            end
        end
    end

    // Channel swap on completion, and underrun detection at the swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= CH_PRI;
            underrun <= 1'b0;
        end else if (finish) begin
            active <= other;
            if (!armed_nx[other]) begin
                underrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pingpong_dma_req.sv
// Ping-pong dual-channel DMA requester (top).
// Buffers samples, requests on the active channel, and swaps channels at
// terminal count.
// Assumes the host drives acknowledge and terminal count synchronously to clk.
module pingpong_dma_req
    import pingpong_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_data,
    output logic [1:0]        dma_req,
    input  logic [1:0]        dma_ack,
    input  logic [1:0]        dma_tc,
    output logic [DATA_W-1:0] xfer_data,
    input  logic [1:0]        ready_set,
    input  logic [1:0]        irq_clr,
    output logic [1:0]        irq,
    output logic              active_ch,
    output logic              overrun,
    output logic              underrun
);
    logic              fifo_empty, fifo_drop;
    logic              handshake, finish, go;
    logic [NUM_CH-1:0] armed;
    chan_e             active;

    pp_sample_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (sample_valid),
        .din  (sample_data),
        .pop  (handshake),
        .dout (xfer_data),
        .empty(fifo_empty),
        .drop (fifo_drop)
    );

    pp_chan_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish   (finish),
        .ready_set(ready_set),
        .irq_clr  (irq_clr),
        .armed    (armed),
        .irq      (irq),
        .active   (active),
        .underrun (underrun)
    );

    // Request qualification: data held, active channel armed, no underrun.
    assign go = !fifo_empty && armed[active] && !underrun;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_req
        // Route the single request to the active channel only.
        assign dma_req[i] = go && (active == chan_e'(i));
    end

    assign handshake = |(dma_req & dma_ack);
    assign finish    = |(dma_req & dma_ack & dma_tc);
    assign active_ch = active;

    // Sticky overrun on a dropped sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (fifo_drop) begin
            overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/pingpong_dma_req_chk.sv
// Checker for pingpong_dma_req, bound to every instance of the top.
module pingpong_dma_req_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic [DATA_W-1:0] sample_data,
    input logic [1:0]        dma_req,
    input logic [1:0]        dma_ack,
    input logic [1:0]        dma_tc,
    input logic [DATA_W-1:0] xfer_data,
    input logic [1:0]        ready_set,
    input logic [1:0]        irq_clr,
    input logic [1:0]        irq,
    input logic              active_ch,
    input logic              overrun,
    input logic              underrun
);
    // R2
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dma_req) <= 1);

    // R2
    req_on_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req[1] |-> active_ch);

    // R3
    req0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req[0] && !dma_ack[0]) |=> (dma_req[0] && $stable(xfer_data)));

    // R3
    req1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req[1] && !dma_ack[1]) |=> (dma_req[1] && $stable(xfer_data)));

    // R5
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dma_req & dma_ack & dma_tc)) |=> (active_ch != $past(active_ch)));

    // R5
    irq0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req[0] && dma_ack[0] && dma_tc[0]) |=> irq[0]);

    // R5
    irq1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req[1] && dma_ack[1] && dma_tc[1]) |=> irq[1]);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9
    underrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (dma_req == 2'b00));

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

bind pingpong_dma_req pingpong_dma_req_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pingpong_dma_req_bench.sv
// Bench: model-checked random host/software traffic plus directed corners.
module pingpong_dma_req_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sample_valid;
    logic [DW-1:0] sample_data;
    logic [1:0]    dma_req, dma_ack, dma_tc, ready_set, irq_clr, irq;
    logic [DW-1:0] xfer_data;
    logic          active_ch, overrun, underrun;

    int n_chk  = 0;
    int n_fail = 0;

    // Requirement model state.
    int        mq[$];
    logic      m_act;
    logic [1:0] m_rdy, m_irq;
    logic      m_ovr, m_unr;

    // Random host bookkeeping.
    int rem [2];

    always #5 clk = ~clk;

    pingpong_dma_req #(.DATA_W(DW), .FIFO_DEPTH(4)) u_pingpong_dma_req (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_data(sample_data), .dma_req(dma_req), .dma_ack(dma_ack),
        .dma_tc(dma_tc), .xfer_data(xfer_data), .ready_set(ready_set),
        .irq_clr(irq_clr), .irq(irq), .active_ch(active_ch),
        .overrun(overrun), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_req();
        if (mq.size() > 0 && m_rdy[m_act] && !m_unr)
            return m_act ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic model_reset();
        mq.delete();
        m_act = 1'b0; m_rdy = 2'b00; m_irq = 2'b00;
        m_ovr = 1'b0; m_unr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sample_valid = 1'b0; sample_data = '0;
        dma_ack = '0; dma_tc = '0; ready_set = '0; irq_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One cycle: drive at negedge, compare, advance model, wait to next negedge.
    task automatic step(input logic sv, input logic [DW-1:0] sd,
                        input logic [1:0] ack, input logic [1:0] tcv,
                        input logic [1:0] rset, input logic [1:0] iclr);
        logic [1:0] er, done, nrdy;
        logic       hs, fin, was_full;
        sample_valid = sv; sample_data = sd; dma_ack = ack; dma_tc = tcv;
        ready_set = rset; irq_clr = iclr;
        #1;
        er = exp_req();
        chk(dma_req == er, "R2", "dma_req", dma_req, er);
        if (er != 2'b00)
            chk(xfer_data == DW'(mq[0]), "R3", "xfer_data", xfer_data, mq[0]);
        chk(irq == m_irq, "R7", "irq", irq, m_irq);
        chk(active_ch == m_act, "R5", "active_ch", active_ch, m_act);
        chk(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
        chk(underrun == m_unr, "R9", "underrun", underrun, m_unr);
        // Advance the requirement model.
        hs       = (er != 2'b00) && ack[m_act];
        fin      = hs && tcv[m_act];
        was_full = (mq.size() == 4);
        if (hs) void'(mq.pop_front());
        if (sv) begin
            if (was_full) m_ovr = 1'b1;
            else mq.push_back(int'(sd));
        end
        done = 2'b00;
        if (fin) done[m_act] = 1'b1;
        nrdy  = (m_rdy | rset) & ~done;
        m_irq = done | (m_irq & ~iclr);
        m_rdy = nrdy;
        if (fin) begin
            m_act = ~m_act;
            if (!nrdy[m_act]) m_unr = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0; dma_ack = '0; dma_tc = '0;
        ready_set = '0; irq_clr = '0;
    endtask

    // Random host and software activity.
    task automatic run_random(input int cycles);
        for (int n = 0; n < cycles; n++) begin
            logic [1:0] ack, tcv, rset, iclr, req_seen;
            req_seen = dma_req;
            ack = '0; tcv = '0; rset = '0; iclr = '0;
            for (int c = 0; c < 2; c++) begin
                if (req_seen[c]) ack[c] = ($urandom % 2) == 0;
                else ack[c] = ($urandom % 8) == 0;            // R4 stray ack
                if (req_seen[c] && ack[c]) tcv[c] = (rem[c] == 1);
                else tcv[c] = ($urandom % 8) == 0;            // R6 stray tc
                if (irq[c]) begin
                    iclr[c] = 1'b1; rset[c] = 1'b1;
                    rem[c] = 1 + ($urandom % 5);
                end
            end
            step(($urandom % 3) == 0, DW'($urandom), ack, tcv, rset, iclr);
            for (int c = 0; c < 2; c++)
                if (req_seen[c] && ack[c] && rem[c] > 0) rem[c]--;
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        do_reset();
        #1;
        // R1 reset state
        chk(dma_req == 2'b00 && irq == 2'b00, "R1", "req/irq", {dma_req, irq}, 0);
        chk(active_ch == 1'b0 && !overrun && !underrun, "R1", "act/flags",
            {active_ch, overrun, underrun}, 0);
        @(negedge clk);

        // R6: terminal count with no request pending does nothing.
        step(0, '0, 2'b00, 2'b00, 2'b11, 2'b00);
        step(0, '0, 2'b01, 2'b01, 2'b00, 2'b00);
        #1 chk(active_ch == 1'b0 && irq == 2'b00, "R6", "act/irq", {active_ch, irq}, 0);
        @(negedge clk);

        // R10: switch with a sample held; it goes out on the secondary next.
        step(1, 16'h00A1, 2'b00, 2'b00, 2'b00, 2'b00);
        step(1, 16'h00A2, 2'b00, 2'b00, 2'b00, 2'b00);
        step(0, '0, 2'b01, 2'b01, 2'b00, 2'b00);
        #1 chk(dma_req == 2'b10 && xfer_data == 16'h00A2, "R10", "req/data",
               {dma_req, xfer_data}, {2'b10, 16'h00A2});
        @(negedge clk);
        // R4: ack on the idle primary leaves the sample in place.
        step(0, '0, 2'b01, 2'b00, 2'b00, 2'b00);
        #1 chk(xfer_data == 16'h00A2, "R4", "xfer_data", xfer_data, 16'h00A2);
        @(negedge clk);

        // R7: clear irq[0]; then set and clear irq[1] in one cycle.
        step(0, '0, 2'b00, 2'b00, 2'b00, 2'b01);
        step(0, '0, 2'b10, 2'b10, 2'b01, 2'b10);
        #1 chk(irq == 2'b10, "R7", "irq set-wins", irq, 2'b10);
        @(negedge clk);

        // R11: ready pulse in the same cycle as completion does not arm.
        step(1, 16'h00B1, 2'b00, 2'b00, 2'b00, 2'b11);
        step(0, '0, 2'b01, 2'b01, 2'b11, 2'b00);
        #1 chk(underrun == 1'b0 && active_ch == 1'b1, "R11", "swap ok",
               {underrun, active_ch}, 2'b01);
        @(negedge clk);
        step(1, 16'h00B2, 2'b00, 2'b00, 2'b00, 2'b00);
        step(0, '0, 2'b10, 2'b10, 2'b00, 2'b00);
        #1 chk(underrun == 1'b1, "R11", "primary disarmed", underrun, 1);
        @(negedge clk);

        // R8: fill past four without acks.
        do_reset();
        step(0, '0, 2'b00, 2'b00, 2'b11, 2'b00);
        for (int k = 0; k < 6; k++)
            step(1, DW'(16'h0C00 + k), 2'b00, 2'b00, 2'b00, 2'b00);
        #1 chk(overrun && xfer_data == 16'h0C00, "R8", "ovr/head",
               {overrun, xfer_data}, {1'b1, 16'h0C00});
        @(negedge clk);
        for (int k = 0; k < 4; k++)
            step(0, '0, 2'b01, 2'b00, 2'b00, 2'b00);
        #1 chk(dma_req == 2'b00, "R8", "drained", dma_req, 0);
        @(negedge clk);

        // R3/R4/R6/R7: random traffic with continuous re-arming.
        do_reset();
        rem[0] = 3; rem[1] = 2;
        step(0, '0, 2'b00, 2'b00, 2'b11, 2'b00);
        run_random(4000);

        // R9: secondary never armed.
        do_reset();
        step(1, 16'h0D01, 2'b00, 2'b00, 2'b01, 2'b00);
        step(1, 16'h0D02, 2'b01, 2'b01, 2'b00, 2'b00);
        #1 chk(underrun == 1'b1 && active_ch == 1'b1, "R9", "unr/act",
               {underrun, active_ch}, 2'b11);
        @(negedge clk);
        step(0, '0, 2'b00, 2'b00, 2'b10, 2'b00);
        step(0, '0, 2'b10, 2'b00, 2'b00, 2'b00);
        #1 chk(dma_req == 2'b00, "R9", "silent", dma_req, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule